// File: doc/BRIEF.md
# Scalar Single-Operand Bit-Manipulation Unit

This unit carries out the one-source scalar operations of a processor's scalar pipe on 32-bit and 64-bit values. Each request carries a 6-bit opcode, a 64-bit source operand, the current 64-bit destination value and the current scalar condition bit. The destination value is needed because conditional moves and single-bit set/clear modify the existing destination. The unit returns the destination result with its write enable, and the new condition bit with its own write enable.

The operations are moves and conditional moves, bitwise inversion, bit reversal, population counts of zeros and of ones, lowest zero/one search, highest set-bit search (unsigned and sign-aware), sign extension of a byte or halfword, single-bit set and clear, group-of-four masks (compressed and whole-width) and bit doubling. Every operation has its own rule for the condition bit: some write it as "result is non-zero", others leave it alone.

Requests enter on a valid/ready stream and results leave on a valid/ready stream through a single output register. A request is accepted on a rising edge when `in_valid` and `in_ready` are both high. Its result is presented on the next cycle and held unchanged until `out_ready` is seen high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure costs no bubble beyond the stall itself.

Top module: `sop1_unit`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`; an accepted request's result appears with `out_valid` high on the cycle after acceptance, and while `out_ready` is low all outputs hold their values.
- R2: After reset `out_valid` is 0 and `in_ready` is 1.
- R3: Opcode encoding: 0/1 move 32/64, 2/3 conditional move, 4/5 invert, 6/7 whole-width group mask, 8/9 reverse, 10/11 zero count, 12/13 one count, 14/15 lowest zero, 16/17 lowest one, 18/19 highest set bit, 20/21 sign-aware highest bit, 22 byte sign extend, 23 halfword sign extend, 24/25 bit clear, 26/27 bit set, 40/41 compressed group mask, 48 absolute value, 55 bit doubling (first of each pair is the 32-bit form); every listed opcode raises `out_dst_we`.
- R4: Move copies the source; conditional move copies the source when the condition bit is 1 and returns the destination unchanged otherwise.
- R5: Invert, reverse (bit i goes to bit W-1-i), sign extension of bits [7:0] or [15:0] to 32 bits, and 32-bit absolute value (most negative value maps to itself) give the arithmetic result.
- R6: Zero and one counts return a 32-bit count of the respective bits in the 32-bit or 64-bit source.
- R7: Lowest-zero and lowest-one searches return the lowest qualifying bit index, or 0xFFFFFFFF when none exists.
- R8: Highest-bit search returns W-1 minus the index of the highest 1; the sign-aware form uses the highest bit differing from bit W-1; both return 0xFFFFFFFF when no such bit exists.
- R9: Bit clear/set returns the destination with the bit at index source[4:0] (32-bit) or source[5:0] (64-bit) cleared or set.
- R10: Compressed group mask sets result bit g when any of source bits [4g+3:4g] is 1; whole-width group mask sets all four bits of such a group.
- R11: Bit doubling copies source bit i (i < 32) to result bits 2i and 2i+1.
- R12: Invert, both counts, both group masks and absolute value raise `out_scc_we` with `out_scc` = (result != 0); all other operations lower `out_scc_we` and pass the incoming condition bit through on `out_scc`.
- R13: An opcode not listed in R3 lowers both write enables, gives `out_data` 0 and passes the incoming condition bit through.
- R14: Every operation with a 32-bit result returns zeros in `out_data[63:32]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 6 | Operation code |
| in_src | input | 64 | Source operand |
| in_dst | input | 64 | Current destination value |
| in_scc | input | 1 | Current condition bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Destination result |
| out_dst_we | output | 1 | Destination is to be written |
| out_scc | output | 1 | New condition bit |
| out_scc_we | output | 1 | Condition bit is to be written |

## Verification
Every result is due exactly one cycle after the edge that accepted its request, and it stays due for as long as `out_ready` holds it back. The bench pushes an independently computed expectation when it sees a request accepted and compares the queue head with the outputs at each falling edge while `out_valid` is high. It pops the head only when the result is drained. Reading at the falling edge after acceptance puts every comparison one register stage behind its stimulus, and random back-pressure exercises the holding rule.

// File: rtl/sop1_pkg.sv
package sop1_pkg;
  localparam int DW  = 64;   // wide operand width
  localparam int HW  = 32;   // narrow operand and count width
  localparam int OPW = 6;    // opcode width
  localparam int NB  = $clog2(HW);
  localparam int WB  = $clog2(DW);

  localparam logic [OPW-1:0] OP_MOV32   = 6'd0;
  localparam logic [OPW-1:0] OP_MOV64   = 6'd1;
  localparam logic [OPW-1:0] OP_CMOV32  = 6'd2;
  localparam logic [OPW-1:0] OP_CMOV64  = 6'd3;
  localparam logic [OPW-1:0] OP_NOT32   = 6'd4;
  localparam logic [OPW-1:0] OP_NOT64   = 6'd5;
  localparam logic [OPW-1:0] OP_GRPW32  = 6'd6;
  localparam logic [OPW-1:0] OP_GRPW64  = 6'd7;
  localparam logic [OPW-1:0] OP_REV32   = 6'd8;
  localparam logic [OPW-1:0] OP_REV64   = 6'd9;
  localparam logic [OPW-1:0] OP_CNT0_32 = 6'd10;
  localparam logic [OPW-1:0] OP_CNT0_64 = 6'd11;
  localparam logic [OPW-1:0] OP_CNT1_32 = 6'd12;
  localparam logic [OPW-1:0] OP_CNT1_64 = 6'd13;
  localparam logic [OPW-1:0] OP_LZ32    = 6'd14;
  localparam logic [OPW-1:0] OP_LZ64    = 6'd15;
  localparam logic [OPW-1:0] OP_LO32    = 6'd16;
  localparam logic [OPW-1:0] OP_LO64    = 6'd17;
  localparam logic [OPW-1:0] OP_HI32    = 6'd18;
  localparam logic [OPW-1:0] OP_HI64    = 6'd19;
  localparam logic [OPW-1:0] OP_HIS32   = 6'd20;
  localparam logic [OPW-1:0] OP_HIS64   = 6'd21;
  localparam logic [OPW-1:0] OP_SX8     = 6'd22;
  localparam logic [OPW-1:0] OP_SX16    = 6'd23;
  localparam logic [OPW-1:0] OP_CLR32   = 6'd24;
  localparam logic [OPW-1:0] OP_CLR64   = 6'd25;
  localparam logic [OPW-1:0] OP_SET32   = 6'd26;
  localparam logic [OPW-1:0] OP_SET64   = 6'd27;
  localparam logic [OPW-1:0] OP_GRPC32  = 6'd40;
  localparam logic [OPW-1:0] OP_GRPC64  = 6'd41;
  localparam logic [OPW-1:0] OP_ABS32   = 6'd48;
  localparam logic [OPW-1:0] OP_DBL     = 6'd55;

  function automatic logic [DW-1:0] zx(input logic [HW-1:0] v);
    return {{(DW-HW){1'b0}}, v};
  endfunction
endpackage

// File: rtl/sop1_scan.sv
// Population count plus lowest and highest set-bit search over one vector.
module sop1_scan #(
  parameter int W  = 32,
  parameter int RW = 32
) (
  input  logic [W-1:0]  vec_i,
  output logic [RW-1:0] pop_o,
  output logic          low_hit_o,
  output logic [RW-1:0] low_idx_o,
  output logic          high_hit_o,
  output logic [RW-1:0] high_idx_o
);
  always_comb begin
    pop_o      = '0;
    low_hit_o  = 1'b0;
    low_idx_o  = '0;
    high_hit_o = 1'b0;
    high_idx_o = '0;
    for (int i = 0; i < W; i++) begin
      pop_o = pop_o + {{(RW-1){1'b0}}, vec_i[i]};
      if (vec_i[i]) begin
        high_hit_o = 1'b1;
        high_idx_o = RW'(i);
      end
    end
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        low_hit_o = 1'b1;
        low_idx_o = RW'(i);
      end
    end
  end
endmodule

// File: rtl/sop1_group.sv
// Groups of four bits: compressed any-set mask and whole-width spread mask.
module sop1_group #(
  parameter int W = 32
) (
  input  logic [W-1:0]   vec_i,
  output logic [W/4-1:0] quad_o,
  output logic [W-1:0]   wide_o
);
  localparam int NG = W / 4;
  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign quad_o[g]       = |vec_i[4*g +: 4];
    assign wide_o[4*g +: 4] = {4{quad_o[g]}};
  end
endmodule

// File: rtl/sop1_unit.sv
module sop1_unit
  import sop1_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0]  in_src,
  input  logic [DW-1:0]  in_dst,
  input  logic           in_scc,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_dst_we,
  output logic           out_scc,
  output logic           out_scc_we
);
  localparam logic [HW-1:0] NONE = '1;

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  logic [HW-1:0] src_n;
  assign src_n = in_src[HW-1:0];

  // operand conditioning shared by counts and searches
  logic flip_sel, sign_sel;
  assign flip_sel = (in_op == OP_CNT0_32) || (in_op == OP_CNT0_64) ||
                    (in_op == OP_LZ32)    || (in_op == OP_LZ64);
  assign sign_sel = (in_op == OP_HIS32) || (in_op == OP_HIS64);

  logic [HW-1:0] scan_n;
  logic [DW-1:0] scan_w;
  assign scan_n = flip_sel ? ~src_n :
                  sign_sel ? (src_n ^ {HW{src_n[HW-1]}}) : src_n;
  assign scan_w = flip_sel ? ~in_src :
                  sign_sel ? (in_src ^ {DW{in_src[DW-1]}}) : in_src;

  logic [HW-1:0] pop_n, lidx_n, hidx_n, pop_w, lidx_w, hidx_w;
  logic          lhit_n, hhit_n, lhit_w, hhit_w;

  sop1_scan #(.W(HW), .RW(HW)) u_scan_n (
    .vec_i(scan_n), .pop_o(pop_n), .low_hit_o(lhit_n), .low_idx_o(lidx_n),
    .high_hit_o(hhit_n), .high_idx_o(hidx_n));
  sop1_scan #(.W(DW), .RW(HW)) u_scan_w (
    .vec_i(scan_w), .pop_o(pop_w), .low_hit_o(lhit_w), .low_idx_o(lidx_w),
    .high_hit_o(hhit_w), .high_idx_o(hidx_w));

  logic [HW/4-1:0] quad_n;
  logic [DW/4-1:0] quad_w;
  logic [HW-1:0]   spread_n;
  logic [DW-1:0]   spread_w;

  sop1_group #(.W(HW)) u_grp_n (.vec_i(src_n),  .quad_o(quad_n), .wide_o(spread_n));
  sop1_group #(.W(DW)) u_grp_w (.vec_i(in_src), .quad_o(quad_w), .wide_o(spread_w));

  // bit reversal and bit doubling are pure wiring
  logic [HW-1:0] rev_n;
  logic [DW-1:0] rev_w, dbl;
  for (genvar i = 0; i < HW; i++) begin : g_rn
    assign rev_n[i]        = src_n[HW-1-i];
    assign dbl[2*i +: 2]   = {2{src_n[i]}};
  end
  for (genvar i = 0; i < DW; i++) begin : g_rw
    assign rev_w[i] = in_src[DW-1-i];
  end

  logic [DW-1:0] res;
  logic          dwe, swe;

  always_comb begin
    res = '0;
    dwe = 1'b1;
    swe = 1'b0;
    unique case (in_op)
      OP_MOV32:   res = zx(src_n);
      OP_MOV64:   res = in_src;
      OP_CMOV32:  res = zx(in_scc ? src_n : in_dst[HW-1:0]);
      OP_CMOV64:  res = in_scc ? in_src : in_dst;
      OP_NOT32:   begin res = zx(~src_n); swe = 1'b1; end
      OP_NOT64:   begin res = ~in_src;    swe = 1'b1; end
      OP_GRPW32:  begin res = zx(spread_n); swe = 1'b1; end
      OP_GRPW64:  begin res = spread_w;     swe = 1'b1; end
      OP_REV32:   res = zx(rev_n);
      OP_REV64:   res = rev_w;
      OP_CNT0_32, OP_CNT1_32: begin res = zx(pop_n); swe = 1'b1; end
      OP_CNT0_64, OP_CNT1_64: begin res = zx(pop_w); swe = 1'b1; end
      OP_LZ32, OP_LO32: res = zx(lhit_n ? lidx_n : NONE);
      OP_LZ64, OP_LO64: res = zx(lhit_w ? lidx_w : NONE);
      OP_HI32, OP_HIS32: res = zx(hhit_n ? (HW'(HW - 1) - hidx_n) : NONE);
      OP_HI64, OP_HIS64: res = zx(hhit_w ? (HW'(DW - 1) - hidx_w) : NONE);
      OP_SX8:     res = zx({{(HW-8){src_n[7]}}, src_n[7:0]});
      OP_SX16:    res = zx({{(HW-16){src_n[15]}}, src_n[15:0]});
      OP_CLR32, OP_SET32: begin
        res = zx(in_dst[HW-1:0]);
        res[in_src[NB-1:0]] = (in_op == OP_SET32);
      end
      OP_CLR64, OP_SET64: begin
        res = in_dst;
        res[in_src[WB-1:0]] = (in_op == OP_SET64);
      end
      OP_GRPC32:  begin res = {{(DW-HW/4){1'b0}}, quad_n}; swe = 1'b1; end
      OP_GRPC64:  begin res = {{(DW-DW/4){1'b0}}, quad_w}; swe = 1'b1; end
      OP_ABS32:   begin res = zx(src_n[HW-1] ? (~src_n + 1'b1) : src_n); swe = 1'b1; end
      OP_DBL:     res = dbl;
      default:    dwe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_dst_we <= 1'b0;
      out_scc    <= 1'b0;
      out_scc_we <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_data   <= res;
      out_dst_we <= dwe;
      out_scc    <= swe ? (res != '0) : in_scc;
      out_scc_we <= swe;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_scc)
      && $stable(out_dst_we) && $stable(out_scc_we)); // R1
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R1
  AST_CMOV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OP_CMOV64 && !in_scc |=> out_data == $past(in_dst)); // R4
  AST_REV_SCC: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == OP_REV32 || in_op == OP_REV64)
      |=> !out_scc_we && out_scc == $past(in_scc)); // R12
  AST_SCC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_scc_we |-> out_scc == (out_data != '0)); // R12
  AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op >= 6'd56 |=> !out_dst_we && !out_scc_we); // R13
  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OP_CNT1_64 |=> out_data[DW-1:HW] == '0); // R14
endmodule

// File: tb/sim_sop1_unit.sv
module sim_sop1_unit;
  localparam int CLK_NS = 10;
  localparam int LIMIT  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_op = '0;
  logic [63:0] in_src = '0;
  logic [63:0] in_dst = '0;
  logic        in_scc = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_dst_we;
  logic        out_scc;
  logic        out_scc_we;

  always #(CLK_NS/2) clk = ~clk;

  sop1_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_dst(in_dst), .in_scc(in_scc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_dst_we(out_dst_we), .out_scc(out_scc), .out_scc_we(out_scc_we));

  typedef struct {
    logic [5:0]  op;
    logic [63:0] d;
    logic        dwe;
    logic        sc;
    logic        swe;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic string optag(input logic [5:0] op);
    case (op)
      0, 1, 2, 3:                  return "R4";
      4, 5, 8, 9, 22, 23, 48:      return "R5";
      10, 11, 12, 13:              return "R6";
      14, 15, 16, 17:              return "R7";
      18, 19, 20, 21:              return "R8";
      24, 25, 26, 27:              return "R9";
      6, 7, 40, 41:                return "R10";
      55:                          return "R11";
      default:                     return "R13";
    endcase
  endfunction

  function automatic bit narrow(input logic [5:0] op);
    return (op <= 6'd24 && op != 1 && op != 3 && op != 5 && op != 7 && op != 9) ||
           op == 26 || op == 40 || op == 48;
  endfunction

  function automatic exp_t model(input logic [5:0] op, input logic [63:0] s,
                                 input logic [63:0] d, input logic c);
    exp_t e;
    int w, n;
    logic sg;
    logic [31:0] v;
    e.op = op; e.d = '0; e.dwe = 1'b1; e.sc = c; e.swe = 1'b0;
    w = (op[0] && op != 6'd55) ? 64 : 32;
    case (op)
      0, 1: e.d = (w == 64) ? s : {32'h0, s[31:0]};
      2:    e.d = {32'h0, c ? s[31:0] : d[31:0]};
      3:    e.d = c ? s : d;
      4:    begin e.d = {32'h0, ~s[31:0]}; e.swe = 1; end
      5:    begin e.d = ~s; e.swe = 1; end
      6, 7: begin
        for (int g = 0; g < w / 4; g++)
          if (s[4*g +: 4] != 0) e.d[4*g +: 4] = 4'hF;
        e.swe = 1;
      end
      8, 9: for (int i = 0; i < w; i++) e.d[i] = s[w-1-i];
      10, 11, 12, 13: begin
        n = 0;
        for (int i = 0; i < w; i++) if (s[i] == (op >= 12)) n++;
        e.d = 64'(n); e.swe = 1;
      end
      14, 15, 16, 17: begin
        e.d = 64'hFFFF_FFFF;
        for (int i = w - 1; i >= 0; i--) if (s[i] == (op >= 16)) e.d = 64'(i);
      end
      18, 19, 20, 21: begin
        e.d = 64'hFFFF_FFFF;
        sg = (op >= 20) ? s[w-1] : 1'b0;
        for (int i = 0; i < w; i++) if (s[i] != sg) e.d = 64'(w - 1 - i);
      end
      22: e.d = {32'h0, {24{s[7]}}, s[7:0]};
      23: e.d = {32'h0, {16{s[15]}}, s[15:0]};
      24, 26: begin e.d = {32'h0, d[31:0]}; e.d[s[4:0]] = (op == 26); end
      25, 27: begin e.d = d; e.d[s[5:0]] = (op == 27); end
      40, 41: begin
        for (int g = 0; g < w / 4; g++) e.d[g] = (s[4*g +: 4] != 0);
        e.swe = 1;
      end
      48: begin
        v = s[31:0];
        e.d = {32'h0, v[31] ? (32'h0 - v) : v};
        e.swe = 1;
      end
      55: for (int i = 0; i < 32; i++) begin e.d[2*i] = s[i]; e.d[2*i+1] = s[i]; end
      default: e.dwe = 1'b0;
    endcase
    if (e.swe) e.sc = (e.d != 0);
    return e;
  endfunction

  // runs 1 time unit after a falling edge, once inputs for this cycle are set
  task automatic observe(output bit acc);
    exp_t e;
    chk(out_valid == (q.size() != 0), "R1 valid", 64'(out_valid), 64'(q.size() != 0));
    chk(in_ready == (!out_valid || out_ready), "R1 ready", 64'(in_ready), 64'(!out_valid || out_ready));
    if (out_valid && q.size() != 0) begin
      e = q[0];
      chk(out_data == e.d, optag(e.op), out_data, e.d);
      chk(out_dst_we == e.dwe, e.dwe ? "R3" : "R13", 64'(out_dst_we), 64'(e.dwe));
      chk(out_scc_we == e.swe && out_scc == e.sc, "R12",
          {62'h0, out_scc_we, out_scc}, {62'h0, e.swe, e.sc});
      if (narrow(e.op)) chk(out_data[63:32] == 0, "R14", out_data, e.d);
      if (out_ready) void'(q.pop_front());
    end
    acc = in_valid && in_ready;
    if (acc) q.push_back(model(in_op, in_src, in_dst, in_scc));
  endtask

  task automatic send(input logic [5:0] op, input logic [63:0] s, input logic [63:0] d, input logic c);
    bit acc;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_op     = op; in_src = s; in_dst = d; in_scc = c;
      out_ready = ($urandom % 4) != 0;
      #1 observe(acc);
    end
    if (($urandom % 8) == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = ($urandom % 2) != 0;
      #1 observe(acc);
    end
  endtask

  logic [63:0] edges [12];
  logic [5:0]  known [25];

  initial begin
    bit acc;
    logic [5:0] op;
    edges = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000,
              64'h8000_0000_0000_0000, 64'h1, 64'h7F, 64'h80, 64'h8000,
              64'h5555_5555_5555_5555, 64'hFFFF_FFFF_0000_0000,
              64'h0000_0000_FFFF_FFFF, 64'h0123_4567_89AB_CDEF};
    known = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9,
              6'd10, 6'd11, 6'd12, 6'd13, 6'd14, 6'd15, 6'd16, 6'd17, 6'd18,
              6'd19, 6'd20, 6'd21, 6'd22, 6'd40, 6'd55};
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R2 out_valid", 64'(out_valid), 64'h0);
    chk(in_ready == 1'b1, "R2 in_ready", 64'(in_ready), 64'h1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R2 after release", 64'(out_valid), 64'h0);

    // directed: every opcode against every edge operand, both condition values
    for (int o = 0; o < 64; o++)
      for (int k = 0; k < 12; k++)
        for (int c = 0; c < 2; c++)
          send(6'(o), edges[k], edges[(k + 5) % 12], c[0]);

    // random operands, biased toward listed opcodes and bit-index sources
    for (int t = 0; t < 3000; t++) begin
      case ($urandom % 4)
        0:       op = 6'($urandom % 64);
        1:       op = 6'(23 + $urandom % 5) ;
        2:       op = ($urandom % 2) ? 6'd41 : 6'd48;
        default: op = known[$urandom % 25];
      endcase
      send(op, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end

    // drain
    repeat (4) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      #1 observe(acc);
    end
    chk(q.size() == 0, "R1 drained", 64'(q.size()), 64'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule